// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Mode

This block is a register-mapped interval timer. A 16-bit prescaler divides the input clock and produces one tick every N cycles. A 16-bit counter counts those ticks up to a terminal value and then signals an expiry. Software programs both values in one period register. It then sets bits in a control register to start the timer, choose one-shot or free-running operation, and enable an interrupt.

Expiry latches a pending flag in a status register. The interrupt line shows that flag while the interrupt enable bit is set. Software clears the flag by writing a one to it.

The same counter can serve as a watchdog. A control bit selects this use. In watchdog use, expiry raises a reset request instead of an interrupt, and the reset request holds until the block is reset. Software keeps the watchdog alive with a service write. This write puts the code 0xA5 into the top byte lane of the control register, with only that lane strobed. It restarts the countdown and changes no control bit.

The register port is a single-cycle write strobe with byte enables and a combinational read mux. It has no back-pressure, and every access completes in the cycle it is presented. The interrupt and reset-request outputs are plain level signals.

Top module: `ptmr_top`

## Requirements
- R1: After reset, all three registers (control at word address 0, period at word address 1, status at word address 2) read as zero, and `irq` and `rst_req` are low.
- R2: The period register holds the prescaler value P in bits 31:16 and the terminal value T in bits 15:0. With P from 1 to 65535 and T from 1 to 65535, expiry comes P*T clock cycles after the write that sets the enable bit.
- R3: A prescaler value of 0 divides the clock by 65536. A terminal value of 0 acts as 1.
- R4: Control bit 12 enables counting. Clearing it stops the timer and holds the count at zero, so no expiry follows.
- R5: When control bit 10 is clear, the timer is one-shot: at expiry the hardware clears bit 12.
- R6: When control bit 10 is set, the timer reloads at expiry and fires again every P*T cycles, with bit 12 left set.
- R7: Expiry sets status bit 0. `irq` equals status bit 0 AND control bit 8. Writing a 1 to any of status bits 3:0 clears the flag, and writing 0 leaves it set.
- R8: When control bit 15 is set, expiry drives `rst_req` high and holds it there until `rst_n` is asserted. The expiry sets no status flag and does not raise `irq`, and counting stops.
- R9: A control-register write with byte enables exactly 4'b1000 and data bits 31:24 equal to 0xA5 restarts the countdown from zero and leaves every control bit unchanged. A write with any other strobe pattern is an ordinary write and does not restart the countdown.
- R10: Any write to the period register restarts the prescaler and the counter from zero, so the new period begins at that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Word address: 0 control, 1 period, 2 status |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Expiry interrupt |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench measures the expiry period in clock cycles for prescaler values 1, 2, 5, 0xFFFF and 0, and for a terminal value of 0. A divider that is off by one, or that treats 0 as divide-by-one, gives a count that differs from the expected value. It also checks the following cases:
- A period write in the middle of a count. A design that ignores the reload expires early.
- A valid service write. A design that fails to restart the countdown asserts the reset request early.
- A service write with an extra strobed lane. A design that accepts it extends the timeout.
- Clearing the status flag with a zero write, and clearing the enable bit in mid-count.
- The reset request after expiry. A design that does not hold it drops it before reset.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int MODE_WD_BIT   = 15;
  localparam int MODE_EN_BIT   = 12;
  localparam int MODE_CONT_BIT = 10;
  localparam int MODE_IE_BIT   = 8;
  localparam logic [7:0] SVC_CODE = 8'hA5;

  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_STATUS = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic wd;
    logic en;
    logic cont;
    logic ie;
  } mode_t;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  // psc-1 wraps 0 to all ones, which gives the divide-by-2^PSC_W case
  logic [PSC_W-1:0] lim;
  logic [PSC_W-1:0] pre_q;

  assign lim  = psc - 1'b1;
  assign tick = run && (pre_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pre_q <= '0;
    else if (clr || !run) pre_q <= '0;
    else if (tick)        pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr |=> !tick || (lim == '0)); // R2
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] term,
  output logic             expire
);
  logic [CNT_W-1:0] tlim;
  logic [CNT_W-1:0] cnt_q;

  // a zero terminal value behaves as one
  assign tlim   = (term == '0) ? '0 : term - 1'b1;
  assign expire = run && tick && !clr && (cnt_q == tlim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || !run) cnt_q <= '0;
    else if (tick) begin
      if (cnt_q == tlim)  cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= tlim); // R2
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16,
  localparam int DW    = PSC_W + CNT_W,
  localparam int NLANE = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [NLANE-1:0] bus_be,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             expire,
  output mode_t            mode,
  output logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] term,
  output logic             restart,
  output logic             flag,
  output logic             rst_req,
  output logic             irq,
  output logic [DW-1:0]    rdata
);
  logic          wr_mode, wr_period, wr_stat, service;
  logic [DW-1:0] period_q;

  assign wr_mode   = bus_sel && bus_wr && (bus_addr == REG_MODE);
  assign wr_period = bus_sel && bus_wr && (bus_addr == REG_PERIOD);
  assign wr_stat   = bus_sel && bus_wr && (bus_addr == REG_STATUS);
  assign service   = wr_mode && (bus_be == NLANE'(1 << (NLANE - 1)))
                     && (bus_wdata[DW-1 -: 8] == SVC_CODE);
  assign restart   = wr_period || service;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      period_q[8*i +: 8] <= '0;
      else if (wr_period && bus_be[i]) period_q[8*i +: 8] <= bus_wdata[8*i +: 8];
    end
  end

  assign psc  = period_q[DW-1 -: PSC_W];
  assign term = period_q[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else begin
      if (expire && (!mode.cont || mode.wd)) mode.en <= 1'b0;
      if (wr_mode && !service && bus_be[1]) begin
        mode.wd   <= bus_wdata[MODE_WD_BIT];
        mode.en   <= bus_wdata[MODE_EN_BIT];
        mode.cont <= bus_wdata[MODE_CONT_BIT];
        mode.ie   <= bus_wdata[MODE_IE_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (expire && !mode.wd) flag <= 1'b1;
    else if (wr_stat && bus_be[0] && (bus_wdata[3:0] != 4'h0)) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else if (expire && mode.wd) rst_req <= 1'b1;
  end

  assign irq = flag && mode.ie && !mode.wd;

  always_comb begin
    rdata = '0;
    case (bus_addr)
      REG_MODE: begin
        rdata[MODE_WD_BIT]   = mode.wd;
        rdata[MODE_EN_BIT]   = mode.en;
        rdata[MODE_CONT_BIT] = mode.cont;
        rdata[MODE_IE_BIT]   = mode.ie;
      end
      REG_PERIOD: rdata = period_q;
      REG_STATUS: rdata[0] = flag;
      default:    rdata = '0;
    endcase
  end

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    expire && (!mode.cont || mode.wd) && !wr_mode |=> !mode.en); // R5
  AST_SVC_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> mode == $past(mode)); // R9
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && bus_be[0] && bus_wdata[0] && !expire |=> !flag); // R7
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int PSC_W = 16,
  parameter int CNT_W = 16,
  localparam int DW    = PSC_W + CNT_W,
  localparam int NLANE = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [NLANE-1:0] bus_be,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq,
  output logic             rst_req
);
  mode_t            mode;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] term;
  logic             restart, tick, expire, flag;

  ptmr_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .expire(expire), .mode(mode), .psc(psc), .term(term),
    .restart(restart), .flag(flag), .rst_req(rst_req), .irq(irq),
    .rdata(bus_rdata)
  );

  ptmr_prescaler #(.PSC_W(PSC_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(mode.en), .clr(restart),
    .psc(psc), .tick(tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(mode.en), .clr(restart),
    .tick(tick), .term(term), .expire(expire)
  );

  AST_WD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    expire && mode.wd |=> rst_req && !irq); // R8
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.en |-> !expire); // R4
endmodule

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ptmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  // psc[63:48], term[47:32], expected period in clocks[31:0]
  localparam logic [63:0] VEC [5] = '{
    {16'd1,      16'd5, 32'd5},
    {16'd2,      16'd3, 32'd6},
    {16'd5,      16'd0, 32'd5},
    {16'hFFFF,   16'd1, 32'd65535},
    {16'h0000,   16'd1, 32'd65536}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_evt(input bit use_rst, output int n);
    bit done = 1'b0;
    n = 0;
    while (!done && n < 70000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (use_rst ? rst_req : irq) done = 1'b1;
    end
  endtask

  task automatic idle_all();
    wr(2'd0, 4'hF, 32'h0);
    wr(2'd2, 4'hF, 32'hF);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], v);
      chk("R1 reg", v, 32'h0);
    end

    // R2/R3 period table
    for (int i = 0; i < 5; i++) begin
      wr(2'd1, 4'hF, VEC[i][63:32]);
      wr(2'd0, 4'hF, 32'h0000_1100);
      wait_evt(1'b0, n);
      chk((i >= 2) ? "R3 period" : "R2 period", n, VEC[i][31:0]);
      if (i == 0) begin
        rd(2'd0, v);
        chk("R5 one-shot clears enable", v, 32'h0000_0100);
      end
      idle_all();
    end

    // R6 continuous
    wr(2'd1, 4'hF, {16'd2, 16'd2});
    wr(2'd0, 4'hF, 32'h0000_1500);
    wait_evt(1'b0, n);
    chk("R6 first period", n, 32'd4);
    wr(2'd2, 4'h1, 32'h1);
    wait_evt(1'b0, n);
    chk("R6 second period (from clear edge)", n, 32'd3);
    rd(2'd0, v);
    chk("R6 enable kept", v, 32'h0000_1500);
    idle_all();

    // R4 stop mid-count
    wr(2'd1, 4'hF, {16'd1, 16'd10});
    wr(2'd0, 4'hF, 32'h0000_1100);
    repeat (3) @(negedge clk);
    wr(2'd0, 4'hF, 32'h0000_0100);
    repeat (20) @(negedge clk);
    chk("R4 no irq after stop", {31'b0, irq}, 32'h0);
    rd(2'd2, v);
    chk("R4 no flag after stop", v, 32'h0);
    idle_all();

    // R7 flag, enable gating, W1C
    wr(2'd1, 4'hF, {16'd1, 16'd3});
    wr(2'd0, 4'hF, 32'h0000_1000);
    repeat (6) @(negedge clk);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    rd(2'd2, v);
    chk("R7 flag set", v, 32'h1);
    wr(2'd0, 4'hF, 32'h0000_0100);
    chk("R7 irq when enabled", {31'b0, irq}, 32'h1);
    wr(2'd2, 4'hF, 32'h0);
    rd(2'd2, v);
    chk("R7 zero write keeps flag", v, 32'h1);
    wr(2'd2, 4'hF, 32'h8);
    rd(2'd2, v);
    chk("R7 one write clears flag", v, 32'h0);
    chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
    idle_all();

    // R10 period write restarts
    wr(2'd1, 4'hF, {16'd1, 16'd10});
    wr(2'd0, 4'hF, 32'h0000_1100);
    repeat (3) @(negedge clk);
    wr(2'd1, 4'hF, {16'd1, 16'd10});
    wait_evt(1'b0, n);
    chk("R10 restart on period write", n, 32'd10);
    idle_all();

    // R9/R8 watchdog with valid service
    wr(2'd1, 4'hF, {16'd1, 16'd8});
    wr(2'd0, 4'hF, 32'h0000_9000);
    repeat (2) @(negedge clk);
    wr(2'd0, 4'b1000, 32'hA500_0000);
    rd(2'd0, v);
    chk("R9 service keeps mode", v, 32'h0000_9000);
    wait_evt(1'b1, n);
    chk("R9 service restarts countdown", n, 32'd7);
    chk("R8 no irq in watchdog", {31'b0, irq}, 32'h0);
    rd(2'd2, v);
    chk("R8 no flag in watchdog", v, 32'h0);
    repeat (10) @(negedge clk);
    chk("R8 rst_req sticky", {31'b0, rst_req}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 rst_req cleared by reset", {31'b0, rst_req}, 32'h0);

    // R9 wrong strobe pattern is not a service
    wr(2'd1, 4'hF, {16'd1, 16'd8});
    wr(2'd0, 4'hF, 32'h0000_9000);
    repeat (2) @(negedge clk);
    wr(2'd0, 4'b1001, 32'hA500_0000);
    wait_evt(1'b1, n);
    chk("R9 two-lane write not a service", n, 32'd5);

    finish_run();
  end
endmodule